// File: doc/BRIEF.md
# Debug Halt Controller

This controller decides when a small processor core stops running normal code and enters a halted debug state, and when it leaves that state. The core reports events as one-cycle pulses: an instruction retired, an exception taken or returned from (with its target exception level), a halt instruction committed, a release from reset, software touching the breakpoint or watchpoint registers, a breakpoint hit and a watchpoint hit. The core also supplies the level of its OS lock. An external debugger supplies a halt request and a restart request.

The block holds one enable bit for each kind of halt cause. There is no master switch. On entry it records the core status and the preferred restart address, and it latches a reason code. It raises `halted`, which the core also uses to hold off interrupts. On a restart it drops `halted` and pulses `resume`. On that pulse the core reloads its program counter from `link_addr` and its status from `saved_stat`.

Top module: `dbg_halt_ctrl`

## Requirements

- R1: A core event halts the core only when its own enable bit is set. With the default of four exception levels the 13-bit enable word is laid out as follows:
  - bit 0: halting-debug enable
  - bit 1: single-step
  - bit 2: reset catch
  - bit 3: lock-release catch
  - bit 4: software-access trap
  - bits 8:5: exception-entry catch, one bit per exception level
  - bits 12:9: exception-return catch, one bit per exception level

  A write to the word takes effect from the following cycle.
- R2: The external halt request halts a running core with no enable bit needed.
- R3: After reset, `halted`, `halt_reason`, `cap_strobe` and `resume` are 0. A halt cause sampled at a clock edge sets `halted` at that edge. The same edge raises `cap_strobe` for exactly one cycle and loads `link_addr` and `saved_stat` with the `next_pc` and `cur_status` values present in that cycle.
- R4: An external halt request while halted has no effect: the reason, `link_addr` and `saved_stat` are unchanged and no strobe appears.
- R5: A restart request while halted clears `halted` at the next edge and pulses `resume` for exactly one cycle, while `link_addr` and `saved_stat` keep the captured values. A restart request while running is ignored.
- R6: If single-step is enabled when a restart is taken, the core halts on the first retired instruction after that restart, with reason 5. Enabling single-step while running has no effect until the next restart.
- R7: Exception catch halts on exception entry (reason 3) or exception return (reason 4) only when the bit for the target level in the matching field is set.
- R8: With reset catch enabled, a reset-release pulse halts the core (reason 2).
- R9: With lock-release catch enabled, a 1-to-0 change of `os_lock` halts the core (reason 9). A 0-to-1 change does not.
- R10: With the trap enabled, a software access to debug registers halts the core (reason 10), unless `ev_acc_mmio` marks it as memory-mapped.
- R11: A halt instruction (reason 6), breakpoint (reason 7) or watchpoint (reason 8) halts the core only if halting-debug is enabled and the authentication input for the current security state is set (`auth_s` when `sec_state`=1, otherwise `auth_ns`).
- R12: When several causes occur in one cycle, the reason is the first in this order:
  - external request (1)
  - reset catch (2)
  - exception entry (3)
  - exception return (4)
  - step (5)
  - halt instruction (6)
  - breakpoint (7)
  - watchpoint (8)
  - lock release (9)
  - software access (10)
- R13: While halted, core events and events that coincide with a restart are ignored.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller |
| cfg_we | input | 1 | Write strobe for the enable word |
| cfg_wdata | input | 5+2*NEL | New enable word |
| dbg_req | input | 1 | External halt request |
| restart_req | input | 1 | External restart request |
| ev_retire | input | 1 | Instruction retired |
| ev_exc_entry | input | 1 | Exception taken |
| ev_exc_ret | input | 1 | Exception return executed |
| ev_el | input | clog2(NEL) | Target exception level of the entry or return |
| ev_hlt | input | 1 | Halt instruction committed |
| ev_core_rst | input | 1 | Core released from warm or cold reset |
| os_lock | input | 1 | Current OS lock level |
| ev_sysreg_acc | input | 1 | Software access to breakpoint/watchpoint registers |
| ev_acc_mmio | input | 1 | Qualifies that access as memory-mapped |
| ev_bkpt | input | 1 | Breakpoint match |
| ev_wpt | input | 1 | Watchpoint match |
| sec_state | input | 1 | 1 when the core runs in secure state |
| auth_ns | input | 1 | Halting allowed in non-secure state |
| auth_s | input | 1 | Halting allowed in secure state |
| cur_status | input | SW | Core status word to save |
| next_pc | input | AW | Preferred restart address |
| halted | output | 1 | Core is in debug state; interrupts held off |
| halt_reason | output | 4 | Code of the cause of the last entry |
| cap_strobe | output | 1 | One-cycle pulse when status and address are captured |
| link_addr | output | AW | Saved restart address |
| saved_stat | output | SW | Saved status word |
| resume | output | 1 | One-cycle pulse telling the core to reload and run |

## Verification

The case that matters most is a retired instruction that completes a single step in the same cycle as other causes fire. The bench arms the step by restarting with single-step enabled. It then drives the retire pulse together with halt-instruction, breakpoint, watchpoint and software-access pulses, and later together with an external request or exception events. The reason code must follow the priority order of R12.

A second collision is a restart arriving in the same cycle as new causes while halted. That restart must win, and the causes must be dropped. Both cases are judged against a behavioural model that is compared on every clock, and against hand-written expected codes.

// File: rtl/dbg_halt_ctrl.sv
`timescale 1ns/1ps
module dbg_halt_ctrl #(
  parameter int NEL = 4,
  parameter int AW  = 32,
  parameter int SW  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [5+2*NEL-1:0] cfg_wdata,
  input  logic               dbg_req,
  input  logic               restart_req,
  input  logic               ev_retire,
  input  logic               ev_exc_entry,
  input  logic               ev_exc_ret,
  input  logic [((NEL>1)?$clog2(NEL):1)-1:0] ev_el,
  input  logic               ev_hlt,
  input  logic               ev_core_rst,
  input  logic               os_lock,
  input  logic               ev_sysreg_acc,
  input  logic               ev_acc_mmio,
  input  logic               ev_bkpt,
  input  logic               ev_wpt,
  input  logic               sec_state,
  input  logic               auth_ns,
  input  logic               auth_s,
  input  logic [SW-1:0]      cur_status,
  input  logic [AW-1:0]      next_pc,
  output logic               halted,
  output logic [3:0]         halt_reason,
  output logic               cap_strobe,
  output logic [AW-1:0]      link_addr,
  output logic [SW-1:0]      saved_stat,
  output logic               resume
);
  localparam int ELW    = (NEL > 1) ? $clog2(NEL) : 1;
  localparam int CFG_W  = 5 + 2*NEL;
  localparam int NCAUSE = 10;
  localparam int B_HDE  = 0;
  localparam int B_STEP = 1;
  localparam int B_RST  = 2;
  localparam int B_UNL  = 3;
  localparam int B_SWA  = 4;
  localparam int B_ENT  = 5;
  localparam int B_RET  = 5 + NEL;

  logic [CFG_W-1:0]  cfg_q;
  logic              lock_q;
  logic              step_armed;
  logic              auth_ok;
  logic              halt_ok;
  logic              el_ok;
  logic [NEL-1:0]    ent_en;
  logic [NEL-1:0]    ret_en;
  logic [NCAUSE-1:0] hit;
  logic [3:0]        cause;

  assign auth_ok = sec_state ? auth_s : auth_ns;
  assign halt_ok = cfg_q[B_HDE] & auth_ok;
  assign el_ok   = ({1'b0, ev_el} < (ELW+1)'(NEL));
  assign ent_en  = cfg_q[B_ENT +: NEL];
  assign ret_en  = cfg_q[B_RET +: NEL];

  assign hit = {
    ev_sysreg_acc & ~ev_acc_mmio & cfg_q[B_SWA],
    lock_q & ~os_lock & cfg_q[B_UNL],
    ev_wpt  & halt_ok,
    ev_bkpt & halt_ok,
    ev_hlt  & halt_ok,
    ev_retire & step_armed,
    ev_exc_ret   & el_ok & ret_en[ev_el],
    ev_exc_entry & el_ok & ent_en[ev_el],
    ev_core_rst & cfg_q[B_RST],
    dbg_req
  };

  always_comb begin
    cause = '0;
    for (int i = NCAUSE-1; i >= 0; i--)
      if (hit[i]) cause = 4'(i + 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      lock_q      <= 1'b0;
      step_armed  <= 1'b0;
      halted      <= 1'b0;
      halt_reason <= '0;
      cap_strobe  <= 1'b0;
      resume      <= 1'b0;
      link_addr   <= '0;
      saved_stat  <= '0;
    end else begin
      lock_q     <= os_lock;
      cap_strobe <= 1'b0;
      resume     <= 1'b0;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (!halted) begin
        if (|hit) begin
          halted      <= 1'b1;
          halt_reason <= cause;
          cap_strobe  <= 1'b1;
          link_addr   <= next_pc;
          saved_stat  <= cur_status;
          step_armed  <= 1'b0;
        end
      end else if (restart_req) begin
        halted     <= 1'b0;
        resume     <= 1'b1;
        step_armed <= cfg_q[B_STEP];
      end
    end
  end
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_chk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbg_req,
  input logic          restart_req,
  input logic [SW-1:0] cur_status,
  input logic [AW-1:0] next_pc,
  input logic          halted,
  input logic [3:0]    halt_reason,
  input logic          cap_strobe,
  input logic [AW-1:0] link_addr,
  input logic [SW-1:0] saved_stat,
  input logic          resume
);
  p_strobe_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> halted && !$past(halted));
  p_entry_has_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> cap_strobe);
  p_capture_values_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> link_addr == $past(next_pc) && saved_stat == $past(cur_status));
  p_req_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted && dbg_req && !restart_req |=> halted && !cap_strobe && $stable(halt_reason) && $stable(link_addr));
  p_resume_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  p_resume_from_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> !halted && $past(halted));
  p_restart_running_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && restart_req |=> !resume);
  p_reason_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (halt_reason >= 4'd1 && halt_reason <= 4'd10));
  p_hold_while_halted_r13: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !restart_req |=> halted && $stable(halt_reason) && $stable(saved_stat));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .restart_req(restart_req),
  .cur_status(cur_status), .next_pc(next_pc), .halted(halted),
  .halt_reason(halt_reason), .cap_strobe(cap_strobe), .link_addr(link_addr),
  .saved_stat(saved_stat), .resume(resume)
);

// File: tb/test_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module test_dbg_halt_ctrl;
  localparam int NEL = 4, AW = 32, SW = 16, CW = 5 + 2*NEL;
  localparam logic [9:0] F_REQ = 10'd1, F_RST = 10'd2, F_ENT = 10'd4, F_RET = 10'd8,
                         F_RTR = 10'd16, F_HLT = 10'd32, F_BKP = 10'd64, F_WPT = 10'd128,
                         F_SWA = 10'd256, F_RS = 10'd512;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [CW-1:0] cfg_wdata = '0;
  logic dbg_req = 0, restart_req = 0, ev_retire = 0, ev_exc_entry = 0, ev_exc_ret = 0;
  logic [1:0] ev_el = '0;
  logic ev_hlt = 0, ev_core_rst = 0, os_lock = 0, ev_sysreg_acc = 0, ev_acc_mmio = 0;
  logic ev_bkpt = 0, ev_wpt = 0, sec_state = 0, auth_ns = 0, auth_s = 0;
  logic [SW-1:0] cur_status = '0; logic [AW-1:0] next_pc = '0;
  logic halted, cap_strobe, resume; logic [3:0] halt_reason;
  logic [AW-1:0] link_addr; logic [SW-1:0] saved_stat;

  always #2 clk = ~clk;

  dbg_halt_ctrl #(.NEL(NEL), .AW(AW), .SW(SW)) i_dbg_halt_ctrl (.*);

  int nchk = 0, nerr = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R3";

  bit m_halted, m_cap, m_res, m_armed, m_lock;
  int m_reason;
  logic [AW-1:0] m_pc; logic [SW-1:0] m_st; logic [CW-1:0] m_cfg;
  int causes[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_halted = 0; m_cap = 0; m_res = 0; m_armed = 0; m_lock = 0;
      m_reason = 0; m_pc = '0; m_st = '0; m_cfg = '0;
    end else begin
      bit unl, ok;
      unl = m_lock && !os_lock;
      m_lock = os_lock;
      ok = m_cfg[0] && (sec_state ? auth_s : auth_ns);
      m_cap = 0; m_res = 0;
      causes.delete();
      if (dbg_req) causes.push_back(1);
      if (ev_core_rst && m_cfg[2]) causes.push_back(2);
      if (ev_exc_entry && m_cfg[5 + ev_el]) causes.push_back(3);
      if (ev_exc_ret && m_cfg[5 + NEL + ev_el]) causes.push_back(4);
      if (ev_retire && m_armed) causes.push_back(5);
      if (ev_hlt && ok) causes.push_back(6);
      if (ev_bkpt && ok) causes.push_back(7);
      if (ev_wpt && ok) causes.push_back(8);
      if (unl && m_cfg[3]) causes.push_back(9);
      if (ev_sysreg_acc && !ev_acc_mmio && m_cfg[4]) causes.push_back(10);
      if (!m_halted) begin
        if (causes.size() > 0) begin
          m_halted = 1; m_reason = causes[0]; m_cap = 1;
          m_pc = next_pc; m_st = cur_status; m_armed = 0;
        end
      end else if (restart_req) begin
        m_halted = 0; m_res = 1; m_armed = m_cfg[1];
      end
      if (cfg_we) m_cfg = cfg_wdata;
    end
  end

  always @(negedge clk) if (chk_on) begin
    nchk++;
    if (halted !== m_halted || int'(halt_reason) != m_reason || cap_strobe !== m_cap ||
        resume !== m_res || link_addr !== m_pc || saved_stat !== m_st) begin
      nerr++;
      $display("FAIL %s model: act h=%0b r=%0d c=%0b s=%0b pc=%h st=%h exp h=%0b r=%0d c=%0b s=%0b pc=%h st=%h",
               cur_req, halted, halt_reason, cap_strobe, resume, link_addr, saved_stat,
               m_halted, m_reason, m_cap, m_res, m_pc, m_st);
    end
  end

  task automatic hchk(string r, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic fire(logic [9:0] m);
    {restart_req, ev_sysreg_acc, ev_wpt, ev_bkpt, ev_hlt, ev_retire,
     ev_exc_ret, ev_exc_entry, ev_core_rst, dbg_req} = m;
    @(negedge clk);
    {restart_req, ev_sysreg_acc, ev_wpt, ev_bkpt, ev_hlt, ev_retire,
     ev_exc_ret, ev_exc_entry, ev_core_rst, dbg_req} = '0;
  endtask

  task automatic setcfg(logic [CW-1:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic halt_as(string r, logic [9:0] m, int code);
    fire(m);
    hchk(r, halted, 1);
    hchk(r, halt_reason, code);
  endtask

  task automatic go;
    fire(F_RS);
    hchk("R5", resume, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    @(negedge clk);
    cur_req = "R3";
    hchk("R3 reset halted", halted, 0);
    hchk("R3 reset reason", halt_reason, 0);
    hchk("R3 reset resume", resume, 0);

    cur_req = "R1"; auth_ns = 1; auth_s = 1;
    fire(F_RST | F_ENT | F_RET | F_RTR | F_HLT | F_BKP | F_WPT | F_SWA);
    os_lock = 1; @(negedge clk); os_lock = 0; @(negedge clk);
    hchk("R1 no enable no halt", halted, 0);

    cur_req = "R2"; next_pc = 32'h1000; cur_status = 16'h0055;
    fire(F_REQ);
    hchk("R2 halted", halted, 1);
    hchk("R2 reason", halt_reason, 1);
    hchk("R3 strobe", cap_strobe, 1);
    hchk("R3 link", int'(link_addr), 32'h1000);
    hchk("R3 status", int'(saved_stat), 16'h0055);
    @(negedge clk);
    hchk("R3 strobe single", cap_strobe, 0);

    cur_req = "R4"; next_pc = 32'h2000; cur_status = 16'h00aa;
    fire(F_REQ);
    hchk("R4 link kept", int'(link_addr), 32'h1000);
    hchk("R4 no strobe", cap_strobe, 0);

    cur_req = "R13"; setcfg(13'h1fff);
    fire(F_HLT | F_BKP | F_RST | F_RTR);
    hchk("R13 reason kept", halt_reason, 1);
    setcfg(13'h0000);

    cur_req = "R5";
    go;
    hchk("R5 running", halted, 0);
    hchk("R5 link held", int'(link_addr), 32'h1000);
    @(negedge clk);
    hchk("R5 pulse single", resume, 0);
    fire(F_RS);
    hchk("R5 restart ignored", resume, 0);

    cur_req = "R11"; setcfg(13'h0001); sec_state = 1; auth_s = 0;
    fire(F_HLT | F_BKP | F_WPT);
    hchk("R11 auth blocks", halted, 0);
    auth_s = 1;
    halt_as("R11 hlt", F_HLT, 6); go;
    sec_state = 0;
    halt_as("R11 bkpt", F_BKP, 7); go;
    halt_as("R11 wpt", F_WPT, 8); go;
    auth_ns = 0;
    fire(F_WPT);
    hchk("R11 ns auth blocks", halted, 0);
    auth_ns = 1;

    cur_req = "R7"; setcfg(13'h1 << (5 + 2)); ev_el = 1;
    fire(F_ENT);
    hchk("R7 wrong level", halted, 0);
    ev_el = 2;
    halt_as("R7 entry", F_ENT, 3); go;
    setcfg(13'h1 << (5 + NEL + 3));
    fire(F_RET);
    hchk("R7 return wrong level", halted, 0);
    ev_el = 3;
    fire(F_ENT);
    hchk("R7 entry not enabled", halted, 0);
    halt_as("R7 return", F_RET, 4); go;

    cur_req = "R8"; setcfg(13'h0004);
    halt_as("R8 reset catch", F_RST, 2); go;

    cur_req = "R9"; setcfg(13'h0008);
    os_lock = 1; @(negedge clk);
    hchk("R9 lock set no halt", halted, 0);
    os_lock = 0; @(negedge clk);
    hchk("R9 unlock halts", halted, 1);
    hchk("R9 reason", halt_reason, 9);
    go;

    cur_req = "R10"; setcfg(13'h0010); ev_acc_mmio = 1;
    fire(F_SWA);
    hchk("R10 mmio ignored", halted, 0);
    ev_acc_mmio = 0;
    halt_as("R10 trap", F_SWA, 10);

    cur_req = "R6"; setcfg(13'h0002);
    go;
    repeat (2) @(negedge clk);
    hchk("R6 wait for retire", halted, 0);
    halt_as("R6 step", F_RTR, 5);
    setcfg(13'h0000); go;
    fire(F_RTR);
    hchk("R6 no arm", halted, 0);
    setcfg(13'h0002);
    fire(F_RTR);
    hchk("R6 enable while running", halted, 0);

    cur_req = "R12"; setcfg(13'h1fff); ev_el = 0;
    fire(F_REQ); go;
    halt_as("R12 step first", F_RTR | F_HLT | F_BKP | F_WPT | F_SWA, 5); go;
    halt_as("R12 req first", F_REQ | F_ENT | F_RTR, 1); go;
    halt_as("R12 rst first", F_ENT | F_RET | F_RST, 2); go;
    halt_as("R12 entry first", F_ENT | F_RET | F_RTR, 3); go;
    halt_as("R12 return first", F_RET | F_RTR, 4);
    setcfg(13'h1ffd); go;
    halt_as("R12 hlt first", F_HLT | F_BKP | F_WPT, 6); go;
    halt_as("R12 bkpt first", F_BKP | F_WPT | F_SWA, 7); go;
    halt_as("R12 wpt first", F_WPT | F_SWA, 8); go;
    os_lock = 1; @(negedge clk); os_lock = 0;
    halt_as("R12 unlock first", F_SWA, 9);

    cur_req = "R13";
    fire(F_RS | F_REQ | F_HLT);
    hchk("R13 restart wins", halted, 0);
    hchk("R13 resume", resume, 1);
    repeat (3) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule